// File: doc/BRIEF.md
# SDRAM Command Timing Monitor

A passive observer that sits beside an SDRAM controller and decodes the command bus on every rising clock edge. It tracks which banks hold an open row, keeps per-bank age counters for activate, precharge and write events, and reports any command that breaks an ordering rule or a minimum or maximum spacing rule. It also checks the power-up sequence and the refresh deadline. It drives nothing on the memory bus. Its only outputs are error reports.

All timing limits are parameters in clock cycles. The integrator converts the device's nanosecond figures for the clock actually used. A spacing of N cycles means that a command issued N edges after the reference event is legal and one issued earlier is not. On the first violation the monitor latches a 4-bit error code and the value of its free-running cycle counter. A mask records every class of violation seen since the last clear.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: A command is decoded only when cke is high and cs_n is low. {ras_n,cas_n,we_n} decodes as 011 activate, 101 read, 100 write, 010 precharge (a10 high means all banks), 001 auto-refresh and 000 mode-register set. 110 is any other command, and 111 is a no-op. With cke low or cs_n high no command is seen, so a column access to a closed bank then raises nothing.
- R2: Any non-no-op command seen before INIT_CYC cycles have passed since reset raises code 1.
- R3: The first mode-register set raises code 2 unless a precharge-all followed by at least INIT_REFS auto-refreshes came before it.
- R4: Any command within T_MRD cycles after a mode-register set raises code 3.
- R5: A read or write to an open bank fewer than T_RCD cycles after that bank's activate raises code 4. An activate to a different bank fewer than T_RRD cycles after the previous activate raises code 5.
- R6: A precharge of an open bank fewer than T_RAS cycles after its activate raises code 6. A row still open T_RAS_MAX+1 cycles after its activate raises code 7, once, in that cycle.
- R7: An activate to a bank fewer than T_RC cycles after that bank's previous activate raises code 8. An activate fewer than T_RP cycles after that bank was closed raises code 9.
- R8: A precharge of an open bank fewer than BURST_LEN-1+T_WR cycles after a write to it raises code 10.
- R9: A refresh debt counter starts once the power-up wait has ended. It grows by one each cycle and shrinks by T_REFI on each auto-refresh, never below zero. When it reaches REF_LIMIT without a refresh in that cycle, code 11 is raised. After that, any activate before two further auto-refreshes raises code 12.
- R10: A read or write to a closed bank raises code 13. An activate to a bank that is already open raises code 14.
- R11: After reset err_flag, err_code, err_cycle and err_mask are zero. The first violation sets err_flag and latches its code and cycle number, which then hold until clr. When several codes fire in one cycle, the lowest code is latched. Bit k-1 of err_mask records code k. A clr cycle zeroes all four outputs, and violations in that same cycle are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Clears all error outputs |
| cke | input | 1 | Clock enable of the bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | $clog2(NB) | Bank address |
| a10 | input | 1 | Address bit 10 (all-bank select on precharge) |
| err_flag | output | 1 | Sticky violation flag |
| err_code | output | 4 | Code of the first violation |
| err_cycle | output | CW | Cycle number of the first violation |
| err_mask | output | 14 | One bit per violation code seen |

## Verification
On every cycle, the bound checker holds the reporting contract. The flag stays set and the first code and cycle stay frozen until clr, and the latched code always has its bit set in the mask. A clear empties everything. Cycles with no decoded command add no command-related bits to the mask. Whether each timing rule fires at exactly the right spacing can only be shown by the directed scenarios. These scenarios place commands one cycle inside and exactly on each limit. They also cover the power-up order, the refresh miss and its two-refresh recovery, and the priority when two rules break at once.

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor #(
  parameter int NB        = 4,
  parameter int CW        = 32,
  parameter int INIT_CYC  = 13334,
  parameter int INIT_REFS = 8,
  parameter int T_MRD     = 2,
  parameter int T_RCD     = 3,
  parameter int T_RRD     = 2,
  parameter int T_RAS     = 6,
  parameter int T_RAS_MAX = 13333,
  parameter int T_RC      = 9,
  parameter int T_RP      = 3,
  parameter int T_WR      = 2,
  parameter int BURST_LEN = 4,
  parameter int T_REFI    = 2080,
  parameter int REF_LIMIT = 8533334
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  cke,
  input  logic                  cs_n,
  input  logic                  ras_n,
  input  logic                  cas_n,
  input  logic                  we_n,
  input  logic [$clog2(NB)-1:0] ba,
  input  logic                  a10,
  output logic                  err_flag,
  output logic [3:0]            err_code,
  output logic [CW-1:0]         err_cycle,
  output logic [13:0]           err_mask
);
  localparam int BAW   = $clog2(NB);
  localparam int NCODE = 14;
  localparam int AW    = $clog2(T_RAS_MAX + 2) + 1;
  localparam int DW    = $clog2(REF_LIMIT + 1);
  localparam int IW    = $clog2(INIT_CYC + 1);
  localparam int RW    = $clog2(INIT_REFS + 1);

  localparam logic [AW-1:0] AMAX   = '1;
  localparam logic [AW-1:0] L_MRD  = AW'(T_MRD);
  localparam logic [AW-1:0] L_RCD  = AW'(T_RCD);
  localparam logic [AW-1:0] L_RRD  = AW'(T_RRD);
  localparam logic [AW-1:0] L_RAS  = AW'(T_RAS);
  localparam logic [AW-1:0] L_RMX1 = AW'(T_RAS_MAX + 1);
  localparam logic [AW-1:0] L_RC   = AW'(T_RC);
  localparam logic [AW-1:0] L_RP   = AW'(T_RP);
  localparam logic [AW-1:0] L_WRG  = AW'(BURST_LEN - 1 + T_WR);
  localparam logic [DW-1:0] L_LIM  = DW'(REF_LIMIT);
  localparam logic [DW-1:0] L_REFI = DW'(T_REFI);
  localparam logic [IW-1:0] L_INIT = IW'(INIT_CYC);
  localparam logic [RW-1:0] L_NREF = RW'(INIT_REFS);

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] a);
    return (a == AMAX) ? a : a + 1'b1;
  endfunction

  wire       sel   = cke & ~cs_n;
  wire [2:0] rcw   = {ras_n, cas_n, we_n};
  wire       c_any = sel && (rcw != 3'b111);
  wire       c_act = sel && (rcw == 3'b011);
  wire       c_rd  = sel && (rcw == 3'b101);
  wire       c_wr  = sel && (rcw == 3'b100);
  wire       c_pre = sel && (rcw == 3'b010);
  wire       c_ref = sel && (rcw == 3'b001);
  wire       c_mrs = sel && (rcw == 3'b000);
  wire       c_col = c_rd | c_wr;

  logic [NB-1:0]  open_q;
  logic [AW-1:0]  act_age [NB];
  logic [AW-1:0]  pre_age [NB];
  logic [AW-1:0]  wr_age  [NB];
  logic [AW-1:0]  any_act_age, mrs_age;
  logic [BAW-1:0] last_ba;
  logic [IW-1:0]  init_cnt;
  logic [RW-1:0]  ref_cnt;
  logic           pall_seen, mrs_done;
  logic [DW-1:0]  debt;
  logic           owe_q;
  logic           rec_q;
  logic [CW-1:0]  cyc_q;

  wire init_done = (init_cnt == L_INIT);
  wire ref_miss  = init_done && !owe_q && !c_ref && (debt == L_LIM);

  logic [NCODE-1:0] hit;
  logic [3:0]       code_now;

  always_comb begin
    hit = '0;
    if (c_any && !init_done)                                     hit[0]  = 1'b1;
    if (c_mrs && !mrs_done && !(pall_seen && ref_cnt == L_NREF)) hit[1]  = 1'b1;
    if (c_any && mrs_age < L_MRD)                                hit[2]  = 1'b1;
    if (c_col && open_q[ba] && act_age[ba] < L_RCD)              hit[3]  = 1'b1;
    if (c_act && ba != last_ba && any_act_age < L_RRD)           hit[4]  = 1'b1;
    if (c_act && act_age[ba] < L_RC)                             hit[7]  = 1'b1;
    if (c_act && pre_age[ba] < L_RP)                             hit[8]  = 1'b1;
    if (ref_miss)                                                hit[10] = 1'b1;
    if (c_act && owe_q)                                          hit[11] = 1'b1;
    if (c_col && !open_q[ba])                                    hit[12] = 1'b1;
    if (c_act && open_q[ba])                                     hit[13] = 1'b1;
    for (int b = 0; b < NB; b++) begin
      if (c_pre && (a10 || ba == BAW'(b)) && open_q[b]) begin
        if (act_age[b] < L_RAS) hit[5] = 1'b1;
        if (wr_age[b] < L_WRG)  hit[9] = 1'b1;
      end
      if (open_q[b] && act_age[b] == L_RMX1) hit[6] = 1'b1;
    end
  end

  always_comb begin
    code_now = '0;
    for (int i = NCODE - 1; i >= 0; i--)
      if (hit[i]) code_now = 4'(i + 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= '0;
      for (int b = 0; b < NB; b++) begin
        act_age[b] <= AMAX;
        pre_age[b] <= AMAX;
        wr_age[b]  <= AMAX;
      end
      any_act_age <= AMAX;
      mrs_age     <= AMAX;
      last_ba     <= '0;
    end else begin
      for (int b = 0; b < NB; b++) begin
        if (c_act && ba == BAW'(b)) begin
          open_q[b]  <= 1'b1;
          act_age[b] <= AW'(1);
        end else begin
          act_age[b] <= bump(act_age[b]);
        end
        if (c_pre && (a10 || ba == BAW'(b)) && open_q[b]) begin
          open_q[b]  <= 1'b0;
          pre_age[b] <= AW'(1);
        end else begin
          pre_age[b] <= bump(pre_age[b]);
        end
        if (c_wr && ba == BAW'(b)) wr_age[b] <= AW'(1);
        else                       wr_age[b] <= bump(wr_age[b]);
      end
      any_act_age <= c_act ? AW'(1) : bump(any_act_age);
      mrs_age     <= c_mrs ? AW'(1) : bump(mrs_age);
      if (c_act) last_ba <= ba;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_cnt  <= '0;
      ref_cnt   <= '0;
      pall_seen <= 1'b0;
      mrs_done  <= 1'b0;
      debt      <= '0;
      owe_q     <= 1'b0;
      rec_q     <= 1'b0;
    end else begin
      if (!init_done) init_cnt <= init_cnt + 1'b1;
      if (c_pre && a10) begin
        pall_seen <= 1'b1;
        ref_cnt   <= '0;
      end else if (c_ref && pall_seen && ref_cnt != L_NREF) begin
        ref_cnt <= ref_cnt + 1'b1;
      end
      if (c_mrs) mrs_done <= 1'b1;

      if (!init_done)       debt <= '0;
      else if (c_ref)       debt <= (debt > L_REFI) ? debt - L_REFI : '0;
      else if (debt != L_LIM) debt <= debt + 1'b1;

      if (ref_miss) begin
        owe_q <= 1'b1;
        rec_q <= 1'b0;
      end else if (owe_q && c_ref) begin
        if (rec_q) owe_q <= 1'b0;
        rec_q <= ~rec_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q     <= '0;
      err_flag  <= 1'b0;
      err_code  <= '0;
      err_cycle <= '0;
      err_mask  <= '0;
    end else begin
      cyc_q <= cyc_q + 1'b1;
      if (clr) begin
        err_flag  <= 1'b0;
        err_code  <= '0;
        err_cycle <= '0;
        err_mask  <= '0;
      end else begin
        err_mask <= err_mask | hit;
        if (!err_flag && |hit) begin
          err_flag  <= 1'b1;
          err_code  <= code_now;
          err_cycle <= cyc_q;
        end
      end
    end
  end
endmodule

// File: rtl/sdram_cmd_monitor_chk.sv
module sdram_cmd_monitor_chk #(
  parameter int NB = 4,
  parameter int CW = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  clr,
  input logic                  cke,
  input logic                  cs_n,
  input logic [$clog2(NB)-1:0] ba,
  input logic                  err_flag,
  input logic [3:0]            err_code,
  input logic [CW-1:0]         err_cycle,
  input logic [13:0]           err_mask
);
  localparam logic [13:0] CMD_BITS = 14'b11101110111111;

  p_sticky_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag && !clr |=> err_flag);

  p_first_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag && !clr |=> $stable(err_code) && $stable(err_cycle));

  p_clear_all_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !err_flag && err_mask == 14'd0 && err_code == 4'd0);

  p_code_in_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |-> err_code != 4'd0 && err_code <= 4'd14 &&
                 ((err_mask >> (err_code - 4'd1)) & 14'd1) != 14'd0);

  p_idle_no_cmd_err_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !clr && (!cke || cs_n) |=> (err_mask & CMD_BITS) == ($past(err_mask) & CMD_BITS));

  logic unused_ba;
  assign unused_ba = ^ba;
endmodule

bind sdram_cmd_monitor sdram_cmd_monitor_chk #(.NB(NB), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .cke(cke), .cs_n(cs_n), .ba(ba),
  .err_flag(err_flag), .err_code(err_code), .err_cycle(err_cycle), .err_mask(err_mask)
);

// File: tb/tb_sdram_cmd_monitor.sv
module tb_sdram_cmd_monitor;
  localparam int P_INIT = 20, P_NREF = 8, P_MRD = 2, P_RCD = 3, P_RRD = 2;
  localparam int P_RAS = 6, P_RMAX = 40, P_RC = 10, P_RP = 3, P_WR = 2, P_BL = 2;
  localparam int P_REFI = 10, P_LIM = 60, CW = 16;

  localparam logic [2:0] OP_ACT = 3'b011, OP_RD = 3'b101, OP_WR = 3'b100;
  localparam logic [2:0] OP_PRE = 3'b010, OP_REF = 3'b001, OP_MRS = 3'b000;

  logic clk = 0, rst_n = 0, clr = 0, cke = 1;
  logic cs_n = 1, ras_n = 1, cas_n = 1, we_n = 1, a10 = 0;
  logic [1:0] ba = '0;
  logic err_flag;
  logic [3:0] err_code;
  logic [CW-1:0] err_cycle;
  logic [13:0] err_mask;
  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [CW-1:0] tb_cyc;

  always #2 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) tb_cyc <= '0;
    else        tb_cyc <= tb_cyc + 1'b1;

  sdram_cmd_monitor #(
    .NB(4), .CW(CW), .INIT_CYC(P_INIT), .INIT_REFS(P_NREF), .T_MRD(P_MRD),
    .T_RCD(P_RCD), .T_RRD(P_RRD), .T_RAS(P_RAS), .T_RAS_MAX(P_RMAX), .T_RC(P_RC),
    .T_RP(P_RP), .T_WR(P_WR), .BURST_LEN(P_BL), .T_REFI(P_REFI), .REF_LIMIT(P_LIM)
  ) dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10), .err_flag(err_flag),
    .err_code(err_code), .err_cycle(err_cycle), .err_mask(err_mask)
  );

  function automatic logic [13:0] mb(input int k);
    return 14'(1) << (k - 1);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic [2:0] op, input logic [1:0] b, input logic hi);
    cs_n = 0; {ras_n, cas_n, we_n} = op; ba = b; a10 = hi;
    @(negedge clk);
    cs_n = 1; {ras_n, cas_n, we_n} = 3'b111; a10 = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clr;
    clr = 1; @(negedge clk); clr = 0;
  endtask

  task automatic do_reset;
    rst_n = 0; cke = 1; clr = 0;
    cs_n = 1; {ras_n, cas_n, we_n} = 3'b111; a10 = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic init_seq(input int refs, input bit tail);
    idle(P_INIT);
    cmd(OP_PRE, 2'd0, 1'b1);
    repeat (refs) cmd(OP_REF, 2'd0, 1'b0);
    cmd(OP_MRS, 2'd0, 1'b0);
    if (tail) idle(P_MRD - 1);
  endtask

  task automatic t_reset;
    do_reset;
    chk("R11 reset flag", 32'(err_flag), 0);
    chk("R11 reset code", 32'(err_code), 0);
    chk("R11 reset cycle", 32'(err_cycle), 0);
    chk("R11 reset mask", 32'(err_mask), 0);
  endtask

  task automatic t_early;
    logic [CW-1:0] c;
    do_reset; idle(5);
    c = tb_cyc;
    cmd(OP_ACT, 2'd0, 1'b0);
    chk("R2 early code", 32'(err_code), 1);
    chk("R2 early cycle", 32'(err_cycle), 32'(c));
    chk("R2 early mask", 32'(err_mask), 32'(mb(1)));
  endtask

  task automatic t_clean;
    do_reset; init_seq(P_NREF, 1'b1);
    cmd(OP_ACT, 2'd0, 1'b0); idle(1);
    cmd(OP_ACT, 2'd1, 1'b0);
    cmd(OP_RD, 2'd0, 1'b0);
    cmd(OP_WR, 2'd0, 1'b0); idle(2);
    cmd(OP_PRE, 2'd0, 1'b0); idle(2);
    cmd(OP_ACT, 2'd0, 1'b0);
    chk("R5 R7 R8 legal spacing flag", 32'(err_flag), 0);
    cke = 0;
    cmd(OP_RD, 2'd2, 1'b0);
    cke = 1;
    chk("R1 cke low ignored mask", 32'(err_mask), 0);
    cmd(OP_WR, 2'd1, 1'b0);
    chk("R1 decode write legal", 32'(err_flag), 0);
  endtask

  task automatic t_mrs_order;
    do_reset; init_seq(P_NREF - 1, 1'b1);
    chk("R3 short refresh code", 32'(err_code), 2);
    chk("R3 mask", 32'(err_mask), 32'(mb(2)));
  endtask

  task automatic t_mrd;
    do_reset; init_seq(P_NREF, 1'b0);
    cmd(OP_ACT, 2'd0, 1'b0);
    chk("R4 mrd code", 32'(err_code), 3);
    chk("R4 mrd mask", 32'(err_mask), 32'(mb(3)));
  endtask

  task automatic t_rcd;
    logic [CW-1:0] c;
    do_reset; init_seq(P_NREF, 1'b1);
    cmd(OP_ACT, 2'd0, 1'b0); idle(1);
    c = tb_cyc;
    cmd(OP_RD, 2'd0, 1'b0);
    chk("R5 rcd code", 32'(err_code), 4);
    chk("R5 rcd cycle", 32'(err_cycle), 32'(c));
  endtask

  task automatic t_rrd;
    do_reset; init_seq(P_NREF, 1'b1);
    cmd(OP_ACT, 2'd0, 1'b0);
    cmd(OP_ACT, 2'd1, 1'b0);
    chk("R5 rrd code", 32'(err_code), 5);
  endtask

  task automatic t_ras_min;
    do_reset; init_seq(P_NREF, 1'b1);
    cmd(OP_ACT, 2'd0, 1'b0); idle(4);
    cmd(OP_PRE, 2'd0, 1'b0);
    chk("R6 ras min code", 32'(err_code), 6);
  endtask

  task automatic t_ras_max;
    logic [CW-1:0] a;
    do_reset; init_seq(P_NREF, 1'b1);
    a = tb_cyc;
    cmd(OP_ACT, 2'd3, 1'b0);
    idle(P_RMAX - 1);
    chk("R6 ras max not yet", 32'(err_flag), 0);
    idle(5);
    chk("R6 ras max code", 32'(err_code), 7);
    chk("R6 ras max cycle", 32'(err_cycle), 32'(a) + P_RMAX + 1);
    chk("R6 ras max once", 32'(err_mask), 32'(mb(7)));
  endtask

  task automatic t_rc;
    do_reset; init_seq(P_NREF, 1'b1);
    cmd(OP_ACT, 2'd0, 1'b0); idle(5);
    cmd(OP_PRE, 2'd0, 1'b0); idle(2);
    cmd(OP_ACT, 2'd0, 1'b0);
    chk("R7 rc code", 32'(err_code), 8);
    chk("R7 rc mask", 32'(err_mask), 32'(mb(8)));
  endtask

  task automatic t_rp;
    do_reset; init_seq(P_NREF, 1'b1);
    cmd(OP_ACT, 2'd0, 1'b0); idle(7);
    cmd(OP_PRE, 2'd0, 1'b0); idle(1);
    cmd(OP_ACT, 2'd0, 1'b0);
    chk("R7 rp code", 32'(err_code), 9);
    chk("R7 rp mask", 32'(err_mask), 32'(mb(9)));
  endtask

  task automatic t_prio;
    do_reset; init_seq(P_NREF, 1'b1);
    cmd(OP_ACT, 2'd0, 1'b0); idle(5);
    cmd(OP_PRE, 2'd0, 1'b0); idle(1);
    cmd(OP_ACT, 2'd0, 1'b0);
    chk("R11 priority code", 32'(err_code), 8);
    chk("R11 priority mask", 32'(err_mask), 32'(mb(8) | mb(9)));
  endtask

  task automatic t_wr;
    do_reset; init_seq(P_NREF, 1'b1);
    cmd(OP_ACT, 2'd0, 1'b0); idle(3);
    cmd(OP_WR, 2'd0, 1'b0); idle(1);
    cmd(OP_PRE, 2'd0, 1'b0);
    chk("R8 write recovery code", 32'(err_code), 10);
  endtask

  task automatic t_ref;
    do_reset; init_seq(P_NREF, 1'b1);
    idle(80);
    chk("R9 refresh late code", 32'(err_code), 11);
    pulse_clr;
    cmd(OP_ACT, 2'd0, 1'b0);
    chk("R9 activate while owing code", 32'(err_code), 12);
    pulse_clr;
    cmd(OP_REF, 2'd0, 1'b0);
    cmd(OP_REF, 2'd0, 1'b0);
    cmd(OP_ACT, 2'd1, 1'b0);
    chk("R9 recovered flag", 32'(err_flag), 0);
  endtask

  task automatic t_state;
    do_reset; init_seq(P_NREF, 1'b1);
    cmd(OP_RD, 2'd2, 1'b0);
    chk("R10 closed access code", 32'(err_code), 13);
    do_reset; init_seq(P_NREF, 1'b1);
    cmd(OP_ACT, 2'd0, 1'b0); idle(11);
    cmd(OP_ACT, 2'd0, 1'b0);
    chk("R10 double activate code", 32'(err_code), 14);
  endtask

  task automatic t_sticky;
    logic [CW-1:0] c;
    do_reset; init_seq(P_NREF, 1'b1);
    c = tb_cyc;
    cmd(OP_RD, 2'd1, 1'b0);
    cmd(OP_ACT, 2'd0, 1'b0); idle(1);
    cmd(OP_RD, 2'd0, 1'b0);
    chk("R11 first code kept", 32'(err_code), 13);
    chk("R11 first cycle kept", 32'(err_cycle), 32'(c));
    chk("R11 mask accumulates", 32'(err_mask), 32'(mb(13) | mb(4)));
    pulse_clr;
    chk("R11 clear flag", 32'(err_flag), 0);
    chk("R11 clear mask", 32'(err_mask), 0);
    chk("R11 clear cycle", 32'(err_cycle), 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset;
    t_early;
    t_clean;
    t_mrs_order;
    t_mrd;
    t_rcd;
    t_rrd;
    t_ras_min;
    t_ras_max;
    t_rc;
    t_rp;
    t_prio;
    t_wr;
    t_ref;
    t_state;
    t_sticky;
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule